// File: doc/BRIEF.md
# Flash Array Bus Access Controller

This block is a bus slave on an AHB-style interface, sitting in front of one flash memory bank. It converts single bus transfers into array read and write cycles. The array address, a 64-bit write word and the read and write strobes all come from registers. Each transfer completes after a programmed number of wait states. Bus reads are 32 bits wide and take one lane of the 64-bit array word.

Before any array cycle starts, the controller applies two gates. The first is a per-master permission mask, with separate masks for reads and writes. The second is an external input that can block writes. The controller also handles an array that reports an error, and a read that arrives while a program or erase is running. Every error is returned as the two-cycle ERROR response. A 128-bit line buffer, two array words deep, serves sequential reads with no wait state. There is no address pipelining. A separate pipelining setting is only compared with the read wait count, and a flag is raised when the pair is illegal.

Top module: `flash_ahb_ctrl`

## Requirements
- R1: A transfer is accepted only when `hsel` is 1, `htrans` is 2'b10 (NONSEQ) or 2'b11 (SEQ), `hready_in` is 1, and the controller is idle. Transfers with `htrans` 2'b00 (IDLE) or 2'b01 (BUSY), or with `hsel` at 0, get a zero-wait OKAY response and start no array cycle.
- R2: A read that misses the line buffer drives `arr_addr` = `haddr` and asserts `arr_re` from the first data-phase cycle for `rd_wait`+1 cycles, with `hready_out` low for those cycles. In the next cycle `hready_out` is 1, `hresp` is 0, and `hrdata` holds bits [31:0] of `arr_rdata` when `haddr[2]` is 0, or bits [63:32] when it is 1.
- R3: During the first data-phase cycle of a write, `hready_out` is low and no strobe is active. At the end of that cycle, `arr_addr`, `arr_wdata` and `arr_we` change together. `arr_we` stays high for `wr_wait`+1 cycles, and the transfer ends with OKAY after `wr_wait`+2 low cycles. `arr_wdata` carries `hwdata` in the lane selected by `haddr[2]` and all ones in the other lane.
- R4: An ERROR response is one cycle with `hresp`=1 and `hready_out`=0. It is followed by cycles with `hresp`=1 and `hready_out`=1, which hold until `hready_in` is 1.
- R5: If bit `hmaster` of `rd_allow` (for a read) or of `wr_allow` (for a write) is 0, the transfer gets an ERROR response starting in its first data-phase cycle, and no array strobe is raised.
- R6: A write accepted while `arr_wr_ok` is 0 gets an ERROR response starting in its first data-phase cycle, and `arr_we` is never raised.
- R7: If `arr_err` is 1 in the last wait cycle of a read or write, the transfer gets an ERROR response after the full wait count: `rd_wait`+2 low cycles for a read and `wr_wait`+3 for a write.
- R8: For a read accepted while `arr_busy` is 1: if `rww_mode` is 3'b000, the read gets an immediate ERROR response and no `arr_re`. For any other code, the read stalls with `hready_out` low until `arr_busy` is seen at 0, and then runs as in R2.
- R9: If `hready_in` is 1 while the controller holds `hready_out` low during an array cycle, no error is reported, even if `arr_err` is 1. The array cycle still runs its full count with `hready_out` low, and `hrdata` is not updated.
- R10: The line buffer covers one 16-byte line, tagged by `haddr[23:4]`, with one 64-bit half per value of `haddr[3]`. A SEQ read that hits a filled half completes with zero wait states and returns the buffered lane. A NONSEQ read always goes to the array. A successful array read fills its half and clears the other half if the tag changed. A launched write empties the buffer.
- R11: `arr_re` and `arr_we` are never high together, and neither is high in a cycle where `hready_out` is 1. `pipe_illegal` is 1 exactly when `pipe_wait` < `rd_wait`.
- R12: After reset, `hready_out` is 1, `hresp` is 0, both strobes are 0 and `hrdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write transfer |
| haddr | input | 24 | Byte address |
| hwdata | input | 32 | Write data, valid in the data phase |
| hmaster | input | 2 | Index of the requesting master |
| hready_in | input | 1 | Bus-wide ready |
| hready_out | output | 1 | Slave ready |
| hresp | output | 1 | 1 = ERROR response |
| hrdata | output | 32 | Read data |
| rd_wait | input | 4 | Read wait-state count |
| wr_wait | input | 4 | Write wait-state count |
| pipe_wait | input | 4 | Pipelining setting, compared only |
| rww_mode | input | 3 | Policy for a read while the array is busy |
| rd_allow | input | 4 | Per-master read permission |
| wr_allow | input | 4 | Per-master write permission |
| pipe_illegal | output | 1 | `pipe_wait` is below `rd_wait` |
| arr_addr | output | 24 | Array address |
| arr_wdata | output | 64 | Array write word |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_rdata | input | 64 | Array read word |
| arr_err | input | 1 | Array error, sampled in the last wait cycle |
| arr_busy | input | 1 | Program or erase in progress |
| arr_wr_ok | input | 1 | External permission for writes |

## Verification
Every combination of read and write wait counts from 0 to 3 is run through four kinds of transfer: a clean read, a clean write, a read with an array error, and a write with an array error. The measured latencies must separate the read count from the write count, and must show the off-by-one added by the first data-phase cycle of a write. Permission masks are swept over all sixteen values for every master. This shows that the bit selected is the requester's bit and that a refused transfer never strobes the array. A busy-array read is run with every read-while-write code, which separates the single error code from the stalling codes. A short run of sequential and non-sequential reads then tells buffer hits from misses, including hits in the second half of the line and a miss after a write. A forced early `hready_in` shows that an array error is swallowed and that the data register is left alone.

// File: rtl/flash_ahb_ctrl.sv
module flash_ahb_ctrl #(
  parameter int AW  = 24,
  parameter int DW  = 64,
  parameter int BW  = 32,
  parameter int NM  = 4,
  parameter int WSW = 4,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [AW-1:0] haddr,
  input  logic [BW-1:0] hwdata,
  input  logic [MW-1:0] hmaster,
  input  logic          hready_in,
  output logic          hready_out,
  output logic          hresp,
  output logic [BW-1:0] hrdata,
  input  logic [WSW-1:0] rd_wait,
  input  logic [WSW-1:0] wr_wait,
  input  logic [WSW-1:0] pipe_wait,
  input  logic [2:0]    rww_mode,
  input  logic [NM-1:0] rd_allow,
  input  logic [NM-1:0] wr_allow,
  output logic          pipe_illegal,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_we,
  output logic          arr_re,
  input  logic [DW-1:0] arr_rdata,
  input  logic          arr_err,
  input  logic          arr_busy,
  input  logic          arr_wr_ok
);
  localparam int LANES = DW / BW;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LSB   = $clog2(BW / 8);
  localparam int HLSB  = $clog2(DW / 8);
  localparam int TLSB  = HLSB + 1;

  typedef enum logic [2:0] {S_IDLE, S_WDATA, S_WWAIT, S_RSTALL, S_RWAIT, S_ERR1, S_ERR2} st_t;

  st_t                   state;
  logic [WSW-1:0]        cnt;
  logic [AW-1:0]         addr_q;
  logic                  abandon;
  logic [BW-1:0]         hrdata_q;
  logic                  we_q, re_q;
  logic [AW-1:0]         arr_addr_q;
  logic [DW-1:0]         wdata_q;
  logic [AW-1:TLSB]      line_tag;
  logic [1:0]            line_vld;
  logic [1:0][DW-1:0]    line_data;

  logic          req, rd_ok, wr_ok, hit;
  logic [BW-1:0] hit_word, rd_word;
  logic [DW-1:0] wword;

  assign hready_out   = (state == S_IDLE) || (state == S_ERR2);
  assign hresp        = (state == S_ERR1) || (state == S_ERR2);
  assign hrdata       = hrdata_q;
  assign arr_addr     = arr_addr_q;
  assign arr_wdata    = wdata_q;
  assign arr_we       = we_q;
  assign arr_re       = re_q;
  assign pipe_illegal = pipe_wait < rd_wait;

  assign req   = (state == S_IDLE) && hsel && htrans[1] && hready_in;
  assign rd_ok = rd_allow[hmaster];
  assign wr_ok = wr_allow[hmaster];
  assign hit   = !hwrite && htrans[0] && line_vld[haddr[HLSB]] && (line_tag == haddr[AW-1:TLSB]);
  assign hit_word = line_data[haddr[HLSB]][int'(haddr[LSB +: LW]) * BW +: BW];
  assign rd_word  = arr_rdata[int'(addr_q[LSB +: LW]) * BW +: BW];

  always_comb begin
    for (int l = 0; l < LANES; l++)
      wword[l*BW +: BW] = (addr_q[LSB +: LW] == LW'(l)) ? hwdata : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      abandon    <= 1'b0;
      hrdata_q   <= '0;
      we_q       <= 1'b0;
      re_q       <= 1'b0;
      arr_addr_q <= '0;
      wdata_q    <= '0;
      line_tag   <= '0;
      line_vld   <= '0;
      line_data  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          addr_q  <= haddr;
          abandon <= 1'b0;
          if (hwrite) begin
            state <= (wr_ok && arr_wr_ok) ? S_WDATA : S_ERR1;
          end else if (!rd_ok) begin
            state <= S_ERR1;
          end else if (hit) begin
            hrdata_q <= hit_word;
          end else if (arr_busy) begin
            state <= (rww_mode == 3'b000) ? S_ERR1 : S_RSTALL;
          end else begin
            arr_addr_q <= haddr;
            re_q       <= 1'b1;
            cnt        <= rd_wait;
            state      <= S_RWAIT;
          end
        end
        S_WDATA: begin
          if (hready_in) begin
            state <= S_IDLE;
          end else begin
            arr_addr_q <= addr_q;
            wdata_q    <= wword;
            we_q       <= 1'b1;
            cnt        <= wr_wait;
            line_vld   <= '0;
            state      <= S_WWAIT;
          end
        end
        S_RSTALL: begin
          if (hready_in) begin
            state <= S_IDLE;
          end else if (!arr_busy) begin
            arr_addr_q <= addr_q;
            re_q       <= 1'b1;
            cnt        <= rd_wait;
            state      <= S_RWAIT;
          end
        end
        S_RWAIT: begin
          if (hready_in) abandon <= 1'b1;
          if (cnt == '0) begin
            re_q <= 1'b0;
            if (abandon || hready_in) begin
              state <= S_IDLE;
            end else if (arr_err) begin
              state <= S_ERR1;
            end else begin
              hrdata_q <= rd_word;
              line_tag <= addr_q[AW-1:TLSB];
              line_data[addr_q[HLSB]] <= arr_rdata;
              if (line_tag != addr_q[AW-1:TLSB]) line_vld <= 2'b01 << addr_q[HLSB];
              else line_vld[addr_q[HLSB]] <= 1'b1;
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WWAIT: begin
          if (hready_in) abandon <= 1'b1;
          if (cnt == '0) begin
            we_q  <= 1'b0;
            state <= (abandon || hready_in || !arr_err) ? S_IDLE : S_ERR1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ERR1: state <= S_ERR2;
        S_ERR2: if (hready_in) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic acc_port;
  assign acc_port = hsel && htrans[1] && hready_in && hready_out && !hresp;

  assert_err_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hready_out) |=> (hresp && hready_out));
  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && hready_out && !hready_in) |=> (hresp && hready_out));
  assert_rd_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_port && !hwrite && !rd_allow[hmaster]) |=> (hresp && !hready_out && !arr_re));
  assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_port && hwrite && (!wr_allow[hmaster] || !arr_wr_ok)) |=> (hresp && !arr_we));
  assert_rww_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_port && !hwrite && htrans == 2'b10 && rd_allow[hmaster] && arr_busy && rww_mode == 3'b000)
      |=> (hresp && !hready_out && !arr_re));
  assert_early_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |-> !hresp);
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_re && arr_we));
  assert_done_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hready_out |-> (!arr_re && !arr_we));
endmodule

// File: tb/flash_ahb_ctrl_test.sv
module flash_ahb_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic        hsel = 0, hwrite = 0, force_rdy = 0;
  logic [1:0]  htrans = 0, hmaster = 0;
  logic [23:0] haddr = 0;
  logic [31:0] hwdata = 0;
  logic        hready_in, hready_out, hresp, pipe_illegal;
  logic [31:0] hrdata;
  logic [3:0]  rd_wait = 0, wr_wait = 0, pipe_wait = 0, rd_allow = 4'hF, wr_allow = 4'hF;
  logic [2:0]  rww_mode = 3'd1;
  logic [23:0] arr_addr;
  logic [63:0] arr_wdata, arr_rdata;
  logic        arr_we, arr_re, arr_err = 0, arr_wr_ok = 1;
  int          cyc = 0, busy_until = 0;
  logic        arr_busy;

  assign hready_in = force_rdy ? 1'b1 : hready_out;
  assign arr_rdata = {8'hA5, arr_addr, 8'h5A, arr_addr};
  assign arr_busy  = cyc < busy_until;
  always @(posedge clk) cyc <= cyc + 1;

  flash_ahb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite), .haddr(haddr),
    .hwdata(hwdata), .hmaster(hmaster), .hready_in(hready_in), .hready_out(hready_out),
    .hresp(hresp), .hrdata(hrdata), .rd_wait(rd_wait), .wr_wait(wr_wait), .pipe_wait(pipe_wait),
    .rww_mode(rww_mode), .rd_allow(rd_allow), .wr_allow(wr_allow), .pipe_illegal(pipe_illegal),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_re(arr_re),
    .arr_rdata(arr_rdata), .arr_err(arr_err), .arr_busy(arr_busy), .arr_wr_ok(arr_wr_ok));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [31:0] lane_of(input [23:0] word_addr, input bit hi);
    return hi ? {8'hA5, word_addr} : {8'h5A, word_addr};
  endfunction

  int waits, we_cyc, re_cyc;
  bit err, err_end, launch_ok;
  logic [31:0] rd;

  task automatic xfer(input bit wr, input bit seq, input [23:0] a, input [31:0] wd, input [1:0] m);
    bit first = 1;
    @(negedge clk);
    hsel = 1; htrans = seq ? 2'b11 : 2'b10; hwrite = wr; haddr = a; hmaster = m;
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwdata = wd;
    waits = 0; we_cyc = 0; re_cyc = 0; err = 0; launch_ok = 1;
    while (!hready_out && waits < 200) begin
      if (hresp) err = 1;
      if (arr_re) re_cyc++;
      if (arr_we) begin
        we_cyc++;
        if (first) begin
          first = 0;
          launch_ok = (arr_addr == a) &&
                      (arr_wdata == (a[2] ? {wd, 32'hFFFF_FFFF} : {32'hFFFF_FFFF, wd}));
        end
      end
      waits++;
      @(negedge clk);
    end
    err_end = hresp;
    rd = hrdata;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(hready_out === 1'b1, "R12 hready_out", hready_out, 1);
    chk(hresp === 1'b0, "R12 hresp", hresp, 0);
    chk(arr_re === 1'b0 && arr_we === 1'b0, "R12 strobes", {arr_re, arr_we}, 0);
    chk(hrdata === 32'h0, "R12 hrdata", hrdata, 0);

    // R1 IDLE / BUSY / unselected transfers
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      hsel = (t != 2); htrans = (t == 2) ? 2'b10 : 2'(t); hwrite = 0; haddr = 24'h40;
      @(negedge clk);
      chk(hready_out && !hresp && !arr_re && !arr_we, "R1 zero-wait okay", {hready_out, hresp, arr_re}, 3'b100);
      hsel = 0; htrans = 0;
    end

    // R2 R3 R7 wait-state sweep
    for (int rw = 0; rw < 4; rw++) begin
      for (int ww = 0; ww < 4; ww++) begin
        rd_wait = 4'(rw); wr_wait = 4'(ww);
        xfer(0, 0, 24'h000200 + 24'(rw*64 + ww*8), 0, 2'(ww));
        chk(waits == rw + 1 && re_cyc == rw + 1 && !err, "R2 read latency", waits, rw + 1);
        chk(rd == lane_of(24'h000200 + 24'(rw*64 + ww*8), 0), "R2 read data low lane", rd,
            lane_of(24'h000200 + 24'(rw*64 + ww*8), 0));
        xfer(0, 0, 24'h000204 + 24'(rw*64), 0, 2'(rw));
        chk(rd == lane_of(24'h000204 + 24'(rw*64), 1), "R2 read data high lane", rd,
            lane_of(24'h000204 + 24'(rw*64), 1));
        xfer(1, 0, 24'h001000 + 24'(ww*4), 32'hC0DE_0000 + 32'(rw*16 + ww), 2'(rw));
        chk(waits == ww + 2 && we_cyc == ww + 1 && !err, "R3 write latency", waits, ww + 2);
        chk(launch_ok, "R3 write launch address and data", launch_ok, 1);
        arr_err = 1;
        xfer(0, 0, 24'h000300, 0, 0);
        chk(err && err_end && waits == rw + 2, "R7 read array error", waits, rw + 2);
        xfer(1, 0, 24'h000300, 32'h1, 0);
        chk(err && err_end && waits == ww + 3, "R7 write array error", waits, ww + 3);
        arr_err = 0;
      end
    end

    // R4 error holds while hready_in low
    rd_allow = 4'h0;
    @(negedge clk);
    hsel = 1; htrans = 2'b10; hwrite = 0; haddr = 24'h10; hmaster = 0;
    @(negedge clk);
    hsel = 0; htrans = 0;
    chk(hresp && !hready_out, "R4 first error cycle", {hresp, hready_out}, 2'b10);
    force_rdy = 0;
    @(negedge clk);
    chk(hresp && hready_out, "R4 second error cycle", {hresp, hready_out}, 2'b11);
    rd_allow = 4'hF;

    // R5 permission sweep
    rd_wait = 1; wr_wait = 1;
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 4; m++) begin
        rd_allow = 4'(p); wr_allow = 4'(15 - p);
        xfer(0, 0, 24'h2000, 0, 2'(m));
        chk(err == !p[m] && (err ? re_cyc == 0 : re_cyc == 2), "R5 read permission", err, !p[m]);
        xfer(1, 0, 24'h2008, 32'h55, 2'(m));
        chk(err == p[m] && (err ? we_cyc == 0 && waits == 1 : we_cyc == 2), "R5 write permission", err, p[m]);
      end
    end
    rd_allow = 4'hF; wr_allow = 4'hF;

    // R6 write gate
    arr_wr_ok = 0;
    xfer(1, 0, 24'h3000, 32'h77, 1);
    chk(err && err_end && we_cyc == 0 && waits == 1, "R6 write gated", we_cyc, 0);
    arr_wr_ok = 1;

    // R8 read while busy
    for (int mode = 0; mode < 8; mode++) begin
      rww_mode = 3'(mode); rd_wait = 2;
      @(negedge clk);
      busy_until = cyc + 4;
      xfer(0, 0, 24'h4000, 0, 0);
      if (mode == 0)
        chk(err && waits == 1 && re_cyc == 0, "R8 busy read terminated", waits, 1);
      else
        chk(!err && waits == 2 + 4 && rd == lane_of(24'h4000, 0), "R8 busy read stalled", waits, 6);
      busy_until = 0;
    end
    rww_mode = 1;

    // R9 early termination swallows error
    rd_wait = 3;
    xfer(0, 0, 24'h5004, 0, 0);
    begin
      logic [31:0] held;
      int low;
      bit saw_err;
      held = hrdata; low = 0; saw_err = 0;
      arr_err = 1;
      @(negedge clk);
      hsel = 1; htrans = 2'b10; hwrite = 0; haddr = 24'h6000;
      @(negedge clk);
      hsel = 0; htrans = 0; force_rdy = 1;
      chk(arr_re === 1'b1, "R9 array read started", arr_re, 1);
      while (!hready_out && low < 50) begin
        if (hresp) saw_err = 1;
        low++;
        @(negedge clk);
      end
      if (hresp) saw_err = 1;
      chk(!saw_err, "R9 no error reported", saw_err, 0);
      chk(low == 4, "R9 array cycle completed", low, 4);
      chk(hrdata == held, "R9 hrdata kept", hrdata, held);
      force_rdy = 0; arr_err = 0;
    end

    // R10 line buffer
    rd_wait = 2;
    xfer(0, 0, 24'h000100, 0, 0);
    chk(waits == 3 && rd == lane_of(24'h000100, 0), "R10 miss fills half 0", waits, 3);
    xfer(0, 1, 24'h000104, 0, 0);
    chk(waits == 0 && rd == lane_of(24'h000100, 1), "R10 seq hit half 0", rd, lane_of(24'h000100, 1));
    xfer(0, 1, 24'h000108, 0, 0);
    chk(waits == 3 && rd == lane_of(24'h000108, 0), "R10 seq miss half 1", waits, 3);
    xfer(0, 1, 24'h00010C, 0, 0);
    chk(waits == 0 && rd == lane_of(24'h000108, 1), "R10 seq hit half 1", rd, lane_of(24'h000108, 1));
    xfer(0, 1, 24'h000104, 0, 0);
    chk(waits == 0 && rd == lane_of(24'h000100, 1), "R10 half 0 still held", rd, lane_of(24'h000100, 1));
    xfer(0, 0, 24'h000104, 0, 0);
    chk(waits == 3 && rd == lane_of(24'h000104, 1), "R10 nonseq goes to array", waits, 3);
    xfer(1, 0, 24'h000110, 32'h9, 0);
    xfer(0, 1, 24'h000104, 0, 0);
    chk(waits == 3, "R10 write empties buffer", waits, 3);
    xfer(0, 1, 24'h000204, 0, 0);
    chk(waits == 3 && rd == lane_of(24'h000204, 1), "R10 other tag misses", waits, 3);

    // R11 pipelining setting check
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pipe_wait = 4'(a); rd_wait = 4'(b);
        #1;
        chk(pipe_illegal == (a < b), "R11 pipe_illegal", pipe_illegal, a < b);
      end
    end

    finish_up();
  end
endmodule